// File: doc/BRIEF.md
# TLB Access Rights Fault Checker

This block sits behind a translation lookaside buffer. It takes the result of one lookup together with the state of the access being made. From these it produces three things: the translated physical address, the mask of rights granted on the page, and at most one fault code.

Privilege is checked against two levels stored with each page. The read level bounds reads. The write level bounds writes. Execution is allowed only when the current level lies between the two. A set of protection-id registers can demote a matching page to read-only. Three per-page flag bits can turn an otherwise legal access into a fault. Those flags are the dirty flag, the break flag and the reference-trap flag.

A physical-mode input bypasses all checking. The block holds no TLB storage and does not record the faulting address. Its outputs are registered by default, which gives a latency of one clock. A parameter selects a purely combinational variant instead.

Top module: `tlb_rights_checker`

## Requirements
- R1: When `phys_mode` is 1, `pa_out` equals `va`, `grant_out` is 3'b111 and `fault_out` is 0, whatever the entry holds.
- R2: When `phys_mode` is 0 and either `hit` or `ent_valid` is 0, `grant_out` is 0. `fault_out` is 1 (instruction TLB miss) for an execute access and 2 (data TLB miss) for any other access.
- R3: When `phys_mode` is 0, `pa_out` is `ent_ppn` concatenated above the low `PAGE_BITS` bits of `va`.
- R4: Lower level numbers mean more privilege. Read is permitted when `cur_pl` ≤ `ent_pl_rd`. Write is permitted when `cur_pl` ≤ `ent_pl_wr`. Execute is permitted when `ent_pl_wr` ≤ `cur_pl` ≤ `ent_pl_rd`. In `grant_out`, bit 0 is read, bit 1 is write and bit 2 is execute.
- R5: `ent_kind` selects which rights the page can ever give: 0 read, 1 read+write, 2 read+execute, 3 read+write+execute, 4 to 7 execute only. For a valid hit, `grant_out` is this set ANDed with the privilege set of R4.
- R6: Protection-id matching applies when `pchk_en` is 1 and `ent_aid` is nonzero. The word {`ent_aid`, 1'b1} is compared with each `PID_W`-bit slice of `pid_flat`, where slice i is bits [i*PID_W +: PID_W]. On any match, the write bit of `grant_out` is cleared, and a write access gets `fault_out` 8. This fault outranks the R7 and R8 faults.
- R7: `acc_kind` is encoded as 0 read, 1 write, 2 execute; 3 is treated as a read. If the access kind's bit is missing from `grant_out`, `fault_out` is 3 (instruction protection) for execute and 4 (data access rights) otherwise. This fault outranks the R8 faults.
- R8: The following faults apply to an access allowed by R6 and R7. A write to a page with `ent_dirty` 0 gives 5 (dirty). A write to a page with `ent_brk` 1 gives 6 (break). A non-execute access to a page with `ent_ref` 1 gives 7 (page reference). If none of these holds, `fault_out` is 0.
- R9: When more than one R8 condition holds, page reference (7) wins over break (6), and break wins over dirty (5).
- R10: With `REG_OUT` = 1, outputs follow the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| phys_mode | input | 1 | Translation bypass |
| pchk_en | input | 1 | Protection-id check enable |
| va | input | ADDR_W | Virtual address of the access |
| hit | input | 1 | Lookup found an entry |
| ent_valid | input | 1 | Found entry is valid |
| ent_ppn | input | ADDR_W-PAGE_BITS | Physical page number of the entry |
| ent_pl_rd | input | PL_W | Read privilege bound (outer level) |
| ent_pl_wr | input | PL_W | Write privilege bound (inner level) |
| ent_kind | input | 3 | Page rights type |
| ent_aid | input | AID_W | Page access id, 0 = public |
| ent_brk | input | 1 | Break-on-write flag |
| ent_dirty | input | 1 | Page already written flag |
| ent_ref | input | 1 | Reference-trap flag |
| cur_pl | input | PL_W | Current privilege level |
| acc_kind | input | 2 | Access kind |
| pid_flat | input | N_PID*(AID_W+1) | Protection-id registers, packed |
| pa_out | output | ADDR_W | Physical address |
| grant_out | output | 3 | Granted rights {X,W,R} |
| fault_out | output | 4 | Fault code, 0 = none |

## Verification
A corrupted rights mask or a wrong privilege compare shows up in the next cycle. It appears as a changed `grant_out` bit, often followed by a protection fault code where none was expected. A broken priority chain or protection-id comparator shows up only when several conditions hold at once. For that reason the stimulus deliberately stacks the flag bits and picks access ids that collide with the register contents. Every cycle is compared against a behavioural model, so any divergence is reported one clock after the input that caused it.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;

   // rights mask bit positions
   localparam int RB = 0;
   localparam int WB = 1;
   localparam int XB = 2;

   // access kinds
   localparam logic [1:0] ACC_RD = 2'd0;
   localparam logic [1:0] ACC_WR = 2'd1;
   localparam logic [1:0] ACC_EX = 2'd2;

   typedef enum logic [3:0] {
      FLT_NONE   = 4'd0,
      FLT_IMISS  = 4'd1,
      FLT_DMISS  = 4'd2,
      FLT_IPROT  = 4'd3,
      FLT_DRIGHT = 4'd4,
      FLT_DIRTY  = 4'd5,
      FLT_BREAK  = 4'd6,
      FLT_PREF   = 4'd7,
      FLT_PIDWR  = 4'd8
   } fault_e;

endpackage

// File: rtl/tlbchk_rights.sv
module tlbchk_rights #(
   parameter int PL_W = 2
) (
   input  logic [PL_W-1:0] cur_pl,
   input  logic [PL_W-1:0] pl_rd,
   input  logic [PL_W-1:0] pl_wr,
   input  logic [2:0]      kind,
   output logic [2:0]      mask
);
   import tlbchk_pkg::*;

   logic may_r, may_w, may_x;
   logic [2:0] type_set;

   assign may_r = (cur_pl <= pl_rd);
   assign may_w = (cur_pl <= pl_wr);
   assign may_x = (pl_wr <= cur_pl) && (cur_pl <= pl_rd);

   always_comb begin
      unique case (kind)
         3'd0:    type_set = 3'b001;
         3'd1:    type_set = 3'b011;
         3'd2:    type_set = 3'b101;
         3'd3:    type_set = 3'b111;
         default: type_set = 3'b100;
      endcase
   end

   always_comb begin
      mask     = '0;
      mask[RB] = type_set[RB] & may_r;
      mask[WB] = type_set[WB] & may_w;
      mask[XB] = type_set[XB] & may_x;
   end

endmodule

// File: rtl/tlbchk_pidmatch.sv
module tlbchk_pidmatch #(
   parameter int AID_W = 18,
   parameter int N_PID = 4,
   localparam int PID_W = AID_W + 1
) (
   input  logic                   en,
   input  logic [AID_W-1:0]       aid,
   input  logic [N_PID*PID_W-1:0] pid_flat,
   output logic                   match
);
   logic [PID_W-1:0] key;
   logic [N_PID-1:0] eq;

   assign key = {aid, 1'b1};

   for (genvar i = 0; i < N_PID; i++) begin : g_cmp
      assign eq[i] = (pid_flat[i*PID_W +: PID_W] == key);
   end

   assign match = en && (|aid) && (|eq);

endmodule

// File: rtl/tlbchk_fault.sv
module tlbchk_fault (
   input  logic       phys,
   input  logic       found,
   input  logic [1:0] kind,
   input  logic [2:0] mask,
   input  logic       pid_hit,
   input  logic       brk,
   input  logic       dirty,
   input  logic       ref_trap,
   output logic [2:0] grant,
   output logic [3:0] fault
);
   import tlbchk_pkg::*;

   logic is_wr, is_ex, allowed;
   logic [2:0] eff;

   assign is_wr = (kind == ACC_WR);
   assign is_ex = (kind == ACC_EX);

   always_comb begin
      eff = mask;
      if (pid_hit) eff[WB] = 1'b0;
   end

   assign allowed = is_ex ? eff[XB] : (is_wr ? eff[WB] : eff[RB]);

   always_comb begin
      grant = eff;
      fault = FLT_NONE;
      if (phys) begin
         grant = 3'b111;
      end else if (!found) begin
         grant = 3'b000;
         fault = is_ex ? FLT_IMISS : FLT_DMISS;
      end else if (pid_hit && is_wr) begin
         fault = FLT_PIDWR;
      end else if (!allowed) begin
         fault = is_ex ? FLT_IPROT : FLT_DRIGHT;
      end else if (ref_trap && !is_ex) begin
         fault = FLT_PREF;
      end else if (brk && is_wr) begin
         fault = FLT_BREAK;
      end else if (!dirty && is_wr) begin
         fault = FLT_DIRTY;
      end
   end

endmodule

// File: rtl/tlb_rights_checker.sv
module tlb_rights_checker #(
   parameter int ADDR_W    = 32,
   parameter int PAGE_BITS = 12,
   parameter int PL_W      = 2,
   parameter int AID_W     = 18,
   parameter int N_PID     = 4,
   parameter bit REG_OUT   = 1'b1,
   localparam int PPN_W    = ADDR_W - PAGE_BITS,
   localparam int PID_W    = AID_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   phys_mode,
   input  logic                   pchk_en,
   input  logic [ADDR_W-1:0]      va,
   input  logic                   hit,
   input  logic                   ent_valid,
   input  logic [PPN_W-1:0]       ent_ppn,
   input  logic [PL_W-1:0]        ent_pl_rd,
   input  logic [PL_W-1:0]        ent_pl_wr,
   input  logic [2:0]             ent_kind,
   input  logic [AID_W-1:0]       ent_aid,
   input  logic                   ent_brk,
   input  logic                   ent_dirty,
   input  logic                   ent_ref,
   input  logic [PL_W-1:0]        cur_pl,
   input  logic [1:0]             acc_kind,
   input  logic [N_PID*PID_W-1:0] pid_flat,
   output logic [ADDR_W-1:0]      pa_out,
   output logic [2:0]             grant_out,
   output logic [3:0]             fault_out
);

   if (PAGE_BITS < 1 || PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("tlb_rights_checker: PAGE_BITS must lie in 1..ADDR_W-1");
   end
   if (PL_W < 1 || N_PID < 1 || AID_W < 1) begin : g_bad_width
      $error("tlb_rights_checker: PL_W, N_PID and AID_W must be positive");
   end

   logic [2:0]        mask;
   logic              pid_hit;
   logic [ADDR_W-1:0] pa_n;
   logic [2:0]        grant_n;
   logic [3:0]        fault_n;

   tlbchk_rights #(.PL_W(PL_W)) u_rights (
      .cur_pl (cur_pl),
      .pl_rd  (ent_pl_rd),
      .pl_wr  (ent_pl_wr),
      .kind   (ent_kind),
      .mask   (mask)
   );

   tlbchk_pidmatch #(.AID_W(AID_W), .N_PID(N_PID)) u_pid (
      .en       (pchk_en),
      .aid      (ent_aid),
      .pid_flat (pid_flat),
      .match    (pid_hit)
   );

   tlbchk_fault u_fault (
      .phys     (phys_mode),
      .found    (hit & ent_valid),
      .kind     (acc_kind),
      .mask     (mask),
      .pid_hit  (pid_hit),
      .brk      (ent_brk),
      .dirty    (ent_dirty),
      .ref_trap (ent_ref),
      .grant    (grant_n),
      .fault    (fault_n)
   );

   assign pa_n = phys_mode ? va : {ent_ppn, va[PAGE_BITS-1:0]};

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pa_out    <= '0;
            grant_out <= '0;
            fault_out <= '0;
         end else begin
            pa_out    <= pa_n;
            grant_out <= grant_n;
            fault_out <= fault_n;
         end
      end
   end else begin : g_comb
      assign pa_out    = pa_n;
      assign grant_out = grant_n;
      assign fault_out = fault_n;
   end

endmodule

// File: rtl/tlbchk_sva.sv
module tlbchk_sva #(
   parameter int ADDR_W = 32,
   parameter int PL_W   = 2,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              phys_mode,
   input logic              hit,
   input logic              ent_valid,
   input logic [ADDR_W-1:0] va,
   input logic [1:0]        acc_kind,
   input logic [PL_W-1:0]   cur_pl,
   input logic [PL_W-1:0]   ent_pl_rd,
   input logic [PL_W-1:0]   ent_pl_wr,
   input logic [ADDR_W-1:0] pa_out,
   input logic [2:0]        grant_out,
   input logic [3:0]        fault_out
);
   if (REG_OUT) begin : g_chk
      // R1
      phys_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         phys_mode |=> (grant_out == 3'b111 && fault_out == 4'd0 && pa_out == $past(va)));

      // R2
      miss_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!phys_mode && !(hit && ent_valid)) |=>
            (grant_out == 3'b000 && (fault_out == 4'd1 || fault_out == 4'd2)));

      // R4
      exec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!phys_mode && (cur_pl < ent_pl_wr || cur_pl > ent_pl_rd)) |=> !grant_out[2]);

      // R8
      dirty_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_out == 4'd5) |-> (grant_out[1] && $past(acc_kind) == 2'd1));

      // R8
      pref_not_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_out == 4'd7) |-> ($past(acc_kind) != 2'd2));

      // R7
      legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fault_out <= 4'd8);
   end
endmodule

bind tlb_rights_checker tlbchk_sva #(.ADDR_W(ADDR_W), .PL_W(PL_W), .REG_OUT(REG_OUT)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .phys_mode (phys_mode),
   .hit       (hit),
   .ent_valid (ent_valid),
   .va        (va),
   .acc_kind  (acc_kind),
   .cur_pl    (cur_pl),
   .ent_pl_rd (ent_pl_rd),
   .ent_pl_wr (ent_pl_wr),
   .pa_out    (pa_out),
   .grant_out (grant_out),
   .fault_out (fault_out)
);

// File: tb/tb_tlb_rights_checker.sv
module tb_tlb_rights_checker;
   localparam int AW = 32;
   localparam int PB = 12;
   localparam int PLW = 2;
   localparam int AIDW = 18;
   localparam int NP = 4;
   localparam int PW = AIDW + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic phys, pchk, hit, vld, brk, dirty, reft;
   logic [AW-1:0] va;
   logic [AW-PB-1:0] ppn;
   logic [PLW-1:0] pl_rd, pl_wr, cur;
   logic [2:0] typ;
   logic [AIDW-1:0] aid;
   logic [1:0] kind;
   logic [NP*PW-1:0] pids;
   logic [AW-1:0] pa_out;
   logic [2:0] grant_out;
   logic [3:0] fault_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic [AW-1:0] e_pa;
   logic [2:0] e_gr;
   logic [3:0] e_f;
   string tag;
   string pa_tag;

   always #10 clk = ~clk;

   tlb_rights_checker dut (
      .clk(clk), .rst_n(rst_n), .phys_mode(phys), .pchk_en(pchk), .va(va),
      .hit(hit), .ent_valid(vld), .ent_ppn(ppn), .ent_pl_rd(pl_rd),
      .ent_pl_wr(pl_wr), .ent_kind(typ), .ent_aid(aid), .ent_brk(brk),
      .ent_dirty(dirty), .ent_ref(reft), .cur_pl(cur), .acc_kind(kind),
      .pid_flat(pids), .pa_out(pa_out), .grant_out(grant_out), .fault_out(fault_out)
   );

   task automatic cmp(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model();
      int r, w, x, ncond, ki;
      bit pm;
      if (phys) begin
         e_pa = va; e_gr = 3'b111; e_f = 0; tag = "R1"; pa_tag = "R1";
         return;
      end
      e_pa = {ppn, va[PB-1:0]}; pa_tag = "R3";
      if (!(hit && vld)) begin
         e_gr = 0; e_f = (kind == 2) ? 4'd1 : 4'd2; tag = "R2";
         return;
      end
      r = (cur <= pl_rd); w = (cur <= pl_wr);
      x = (pl_wr <= cur && cur <= pl_rd);
      case (typ)
         3'd0: e_gr = {1'b0, 1'b0, r[0]};
         3'd1: e_gr = {1'b0, w[0], r[0]};
         3'd2: e_gr = {x[0], 1'b0, r[0]};
         3'd3: e_gr = {x[0], w[0], r[0]};
         default: e_gr = {x[0], 1'b0, 1'b0};
      endcase
      tag = "R5";
      pm = 0;
      if (pchk && aid != 0)
         for (int i = 0; i < NP; i++)
            if (pids[i*PW +: PW] == {aid, 1'b1}) pm = 1;
      if (pm) begin e_gr[1] = 0; tag = "R6"; end
      ki = (kind == 2) ? 2 : (kind == 1) ? 1 : 0;
      ncond = 0;
      if (reft && kind != 2) ncond++;
      if (brk && kind == 1) ncond++;
      if (!dirty && kind == 1) ncond++;
      if (pm && kind == 1) begin e_f = 8; tag = "R6"; end
      else if (!e_gr[ki]) begin e_f = (kind == 2) ? 4'd3 : 4'd4; tag = "R7"; end
      else if (ncond > 0) begin
         tag = (ncond > 1) ? "R9" : "R8";
         if (reft && kind != 2) e_f = 7;
         else if (brk && kind == 1) e_f = 6;
         else e_f = 5;
      end else begin
         e_f = 0; if (!pm) tag = "R4";
      end
   endtask

   // apply current inputs, wait one edge (R10 latency), compare
   task automatic step();
      model();
      @(negedge clk);
      cmp(pa_tag, "pa", pa_out, e_pa);
      cmp(tag, "grant", grant_out, e_gr);
      cmp(tag, "fault", fault_out, e_f);
   endtask

   task automatic defaults();
      phys = 0; pchk = 0; hit = 1; vld = 1; ppn = 20'hABCDE;
      pl_rd = 3; pl_wr = 0; typ = 3; aid = 0; brk = 0; dirty = 1; reft = 0;
      cur = 0; kind = 0; va = 32'h1234_5678; pids = '0;
   endtask

   initial begin
      defaults();
      phys = 1; kind = 1;
      repeat (2) @(negedge clk);
      // R10 reset state
      cmp("R10", "pa", pa_out, 0);
      cmp("R10", "grant", grant_out, 0);
      cmp("R10", "fault", fault_out, 0);
      rst_n = 1;
      // R1
      va = 32'hDEAD_BEEF; hit = 0; step();
      // R2
      defaults(); hit = 0; kind = 2; step();
      defaults(); vld = 0; kind = 0; step();
      defaults(); vld = 0; kind = 3; step();
      // R5 / R7
      defaults(); typ = 0; kind = 1; step();
      defaults(); typ = 1; kind = 2; step();
      defaults(); typ = 5; kind = 0; step();
      defaults(); typ = 6; kind = 2; pl_wr = 0; cur = 2; step();
      // R4 privilege window
      defaults(); pl_rd = 1; cur = 2; step();
      defaults(); pl_rd = 2; pl_wr = 1; cur = 0; kind = 2; step();
      defaults(); pl_rd = 2; pl_wr = 1; cur = 1; kind = 2; step();
      defaults(); pl_wr = 1; cur = 2; kind = 1; step();
      // R6 protection ids
      defaults(); pchk = 1; aid = 5; pids[2*PW +: PW] = {18'd5, 1'b1}; kind = 1; step();
      kind = 0; step();
      kind = 2; typ = 3; step();
      defaults(); pchk = 1; aid = 0; pids[0 +: PW] = 19'd1; kind = 1; step();
      defaults(); pchk = 0; aid = 5; pids[PW +: PW] = {18'd5, 1'b1}; kind = 1; step();
      defaults(); pchk = 1; aid = 5; pids[3*PW +: PW] = {18'd5, 1'b0}; kind = 1; step();
      defaults(); pchk = 1; aid = 5; pids[3*PW +: PW] = {18'd5, 1'b1}; typ = 0; kind = 1; step();
      // R8 / R9
      defaults(); kind = 1; dirty = 0; step();
      defaults(); kind = 1; brk = 1; dirty = 0; step();
      defaults(); kind = 1; reft = 1; brk = 1; dirty = 0; step();
      defaults(); kind = 2; reft = 1; step();
      defaults(); kind = 0; reft = 1; step();
      defaults(); kind = 0; brk = 1; dirty = 0; step();
      defaults(); kind = 3; reft = 1; step();
      // mixed random patterns
      for (int n = 0; n < 3000; n++) begin
         phys = ($urandom_range(0, 15) == 0);
         pchk = $urandom_range(0, 1);
         hit = ($urandom_range(0, 7) != 0);
         vld = ($urandom_range(0, 7) != 0);
         ppn = $urandom; va = $urandom;
         pl_rd = $urandom; pl_wr = $urandom; cur = $urandom;
         typ = $urandom; kind = $urandom;
         aid = $urandom_range(0, 3);
         brk = $urandom_range(0, 1); dirty = $urandom_range(0, 1);
         reft = $urandom_range(0, 1);
         for (int i = 0; i < NP; i++)
            pids[i*PW +: PW] = {18'($urandom_range(0, 3)), 1'($urandom_range(0, 1))};
         step();
      end
      // R10 reset clears again
      rst_n = 0; @(negedge clk);
      cmp("R10", "grant", grant_out, 0);
      cmp("R10", "fault", fault_out, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule